// File: doc/BRIEF.md
# Ultrasonic Ping Timing Generator

This block turns one fast reference clock, nominally about 465 kHz, into the periodic timing signals used by an ultrasonic ranging cycle. A three-state prescaler produces a one-cycle advance strobe at about 155 kHz. That strobe steps a 9-bit slot counter, so one frame is 512 slots, or roughly 3.3 ms. Every output is decoded from the slot number and registered on the reference clock, which keeps the outputs free of the decode glitches a rippled divider would produce.

The outputs are as follows:
- a burst carrier at about 39 kHz, which is reference/12;
- a measurement count clock at about 19.5 kHz;
- a transmit window about 100 µs wide;
- a receive-blanking window about 410 µs wide;
- two late strobes, each high only in the second half of its window;
- the transducer drive, which is the carrier gated by the transmit window. It gives four carrier pulses per frame.

All signals are plain control levels. The block has no data stream, so it has no valid/ready interface and no back-pressure. Downstream logic samples the levels directly.

Top module: `ping_timing_gen`

## Requirements
- R1: Let e count the rising edges of `clk` after `rst` is released, with the first such edge being e=0. After edge e, the outputs show slot s = floor(e/3) mod 512. So the outputs change at most once every three reference cycles.
- R2: Slots wrap from 511 back to 0. The frame repeats every 1536 reference cycles.
- R3: `carrier` equals bit 1 of s, and `count_clk` equals bit 2 of s.
- R4: `tx_win` is high exactly for slots 0 to 15.
- R5: `blank_win` is high exactly for slots 0 to 63. Both windows therefore rise together at slot 0.
- R6: `tx_late` is high exactly for slots 8 to 15. `blank_late` is high exactly for slots 32 to 63.
- R7: `burst` equals `carrier` AND `tx_win`. It has exactly four rising edges in each frame.
- R8: Any rising edge with `rst` high drives every output low. It also restarts the timing of R1 from e=0 at the first edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (~465 kHz) |
| rst | input | 1 | Synchronous reset, active high |
| carrier | output | 1 | Burst carrier, reference/12 |
| count_clk | output | 1 | Measurement count clock, reference/24 |
| tx_win | output | 1 | Transmit window, slots 0 to 15 |
| blank_win | output | 1 | Receive-blanking window, slots 0 to 63 |
| tx_late | output | 1 | Second half of the transmit window |
| blank_late | output | 1 | Second half of the blanking window |
| burst | output | 1 | Gated carrier for the transducer driver |

## Verification
The bench plays a long free run of more than three frames. This shows whether the prescaler really holds every slot for three cycles and whether the slot counter wraps at 512 rather than at some other power of two. A reset applied in the middle of a frame separates a design that clears its outputs and restarts at slot 0 from one that only gates its outputs or resumes at the old slot. In every frame the bench counts the rising edges of the gated burst and compares each late strobe against its window. A misplaced tap or a wrong window length then shows up as a wrong edge count or a wrong slot boundary.

// File: rtl/ping_pkg.sv
package ping_pkg;
  typedef struct packed {
    logic burst;
    logic blank_late;
    logic tx_late;
    logic blank_win;
    logic tx_win;
    logic count_clk;
    logic carrier;
  } ping_out_t;
endpackage

// File: rtl/ping_prescale.sv
module ping_prescale #(
  parameter int unsigned DIV = 3
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/ping_slot_counter.sv
module ping_slot_counter #(
  parameter int unsigned SLOT_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  output logic [SLOT_W-1:0] slot
);
  always_ff @(posedge clk) begin
    if (rst)      slot <= '0;
    else if (adv) slot <= slot + 1'b1;
  end
endmodule

// File: rtl/ping_window.sv
module ping_window #(
  parameter int unsigned SLOT_W = 9,
  parameter int unsigned LEN    = 16
) (
  input  logic [SLOT_W-1:0] slot,
  output logic              win,
  output logic              late
);
  localparam logic [SLOT_W:0] LEN_X  = (SLOT_W+1)'(LEN);
  localparam logic [SLOT_W:0] HALF_X = (SLOT_W+1)'(LEN / 2);

  logic [SLOT_W:0] slot_x;
  assign slot_x = {1'b0, slot};
  assign win    = slot_x < LEN_X;
  assign late   = win && (slot_x >= HALF_X);
endmodule

// File: rtl/ping_timing_gen.sv
module ping_timing_gen #(
  parameter int unsigned PRE_DIV     = 3,
  parameter int unsigned SLOT_W      = 9,
  parameter int unsigned CARRIER_TAP = 1,
  parameter int unsigned COUNT_TAP   = 2,
  parameter int unsigned TX_SLOTS    = 16,
  parameter int unsigned BLANK_SLOTS = 64
) (
  input  logic clk,
  input  logic rst,
  output logic carrier,
  output logic count_clk,
  output logic tx_win,
  output logic blank_win,
  output logic tx_late,
  output logic blank_late,
  output logic burst
);
  import ping_pkg::*;

  localparam int unsigned NWIN = 2;
  localparam int unsigned WIN_LEN [NWIN] = '{TX_SLOTS, BLANK_SLOTS};

  logic              tick;
  logic [SLOT_W-1:0] slot;
  logic [NWIN-1:0]   win_v;
  logic [NWIN-1:0]   late_v;
  ping_out_t         nxt;
  ping_out_t         q;

  ping_prescale #(.DIV(PRE_DIV)) u_pre (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  ping_slot_counter #(.SLOT_W(SLOT_W)) u_slot (
    .clk (clk),
    .rst (rst),
    .adv (tick),
    .slot(slot)
  );

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    ping_window #(.SLOT_W(SLOT_W), .LEN(WIN_LEN[g])) u_win (
      .slot(slot),
      .win (win_v[g]),
      .late(late_v[g])
    );
  end

  always_comb begin
    nxt            = '0;
    nxt.carrier    = slot[CARRIER_TAP];
    nxt.count_clk  = slot[COUNT_TAP];
    nxt.tx_win     = win_v[0];
    nxt.blank_win  = win_v[1];
    nxt.tx_late    = late_v[0];
    nxt.blank_late = late_v[1];
    nxt.burst      = win_v[0] & slot[CARRIER_TAP];
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  assign carrier    = q.carrier;
  assign count_clk  = q.count_clk;
  assign tx_win     = q.tx_win;
  assign blank_win  = q.blank_win;
  assign tx_late    = q.tx_late;
  assign blank_late = q.blank_late;
  assign burst      = q.burst;
endmodule

// File: rtl/ping_timing_chk.sv
module ping_timing_chk (
  input logic clk,
  input logic rst,
  input logic carrier,
  input logic count_clk,
  input logic tx_win,
  input logic blank_win,
  input logic tx_late,
  input logic blank_late,
  input logic burst
);
  AST_BURST_GATED: assert property (@(posedge clk) disable iff (rst)
    burst |-> (tx_win && carrier)); // R7
  AST_TX_INSIDE_BLANK: assert property (@(posedge clk) disable iff (rst)
    tx_win |-> blank_win); // R5
  AST_TX_LATE_INSIDE: assert property (@(posedge clk) disable iff (rst)
    tx_late |-> tx_win); // R6
  AST_BLANK_LATE_INSIDE: assert property (@(posedge clk) disable iff (rst)
    blank_late |-> blank_win); // R6
  AST_WIN_START_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_win) |-> ($rose(blank_win) && !tx_late && !carrier && !count_clk)); // R4
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !(carrier || count_clk || tx_win || blank_win ||
                     tx_late || blank_late || burst)); // R8
endmodule

bind ping_timing_gen ping_timing_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .carrier   (carrier),
  .count_clk (count_clk),
  .tx_win    (tx_win),
  .blank_win (blank_win),
  .tx_late   (tx_late),
  .blank_late(blank_late),
  .burst     (burst)
);

// File: tb/ping_timing_gen_test.sv
module ping_timing_gen_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic carrier, count_clk, tx_win, blank_win, tx_late, blank_late, burst;

  always #2 clk = ~clk;

  ping_timing_gen uut (
    .clk(clk), .rst(rst), .carrier(carrier), .count_clk(count_clk),
    .tx_win(tx_win), .blank_win(blank_win), .tx_late(tx_late),
    .blank_late(blank_late), .burst(burst)
  );

  typedef struct {
    logic [6:0] v;
    bit         in_rst;
    int         e;
  } exp_t;

  exp_t exp_q[$];
  int   compared   = 0;
  int   mismatched = 0;
  int   e_cnt      = 0;
  bit   done       = 0;

  function automatic logic [6:0] model(input int e);
    int s;
    logic c, t;
    s = (e / 3) % 512;
    c = s[1];
    t = (s < 16);
    // {burst, blank_late, tx_late, blank_win, tx_win, count_clk, carrier}
    return {t & c, (s >= 32 && s < 64), (s >= 8 && s < 16), (s < 64), t, s[2], c};
  endfunction

  task automatic step(input logic r);
    exp_t it;
    @(negedge clk);
    rst = r;
    @(posedge clk);
    it.in_rst = r;
    if (r) begin
      it.v = '0; it.e = -1; e_cnt = 0;
    end else begin
      it.v = model(e_cnt); it.e = e_cnt; e_cnt++;
    end
    exp_q.push_back(it);
  endtask

  task automatic check(input string req, input string what, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  logic [6:0] prev_act = '0;
  bit         prev_ok  = 0;
  int         pulses   = 0;

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t it;
      logic [6:0] a;
      int s;
      it = exp_q.pop_front();
      a = {burst, blank_late, tx_late, blank_win, tx_win, count_clk, carrier};
      if (it.in_rst) begin
        check("R8", "outputs during reset", |a, 1'b0);
        prev_ok = 0;
      end else begin
        s = (it.e / 3) % 512;
        if (it.e == 0) check("R8", "tx_win at first edge after release", a[2], 1'b1);
        if (prev_ok && (it.e % 3 != 0))
          check("R1", "outputs hold within slot", a == prev_act, 1'b1);
        if (s == 0 && it.e >= 1536 && it.e % 3 == 0)
          check("R2", "tx_win at frame wrap", a[2], 1'b1);
        if (s == 511)
          check("R2", "blank_win at last slot", a[3], 1'b0);
        check("R3", "carrier", a[0], it.v[0]);
        check("R3", "count_clk", a[1], it.v[1]);
        check("R4", "tx_win", a[2], it.v[2]);
        check("R5", "blank_win", a[3], it.v[3]);
        check("R6", "tx_late", a[4], it.v[4]);
        check("R6", "blank_late", a[5], it.v[5]);
        check("R7", "burst", a[6], it.v[6]);
        if (s == 0 && it.e % 3 == 0) pulses = 0;
        if (a[6] && !(prev_ok && prev_act[6])) pulses++;
        if (s == 16 && it.e % 3 == 0) begin
          compared++;
          if (pulses != 4) begin
            mismatched++;
            $display("FAIL R7 burst pulses per frame actual=%0d expected=4", pulses);
          end
        end
        prev_ok = 1;
      end
      prev_act = a;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) step(1'b1);
    for (int i = 0; i < 4700; i++) step(1'b0);
    for (int i = 0; i < 3; i++) step(1'b1);
    for (int i = 0; i < 2100; i++) step(1'b0);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule